// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single-register load or store and, in the same cycle, the value the base register may be updated with. It takes the base register contents and one of four offset sources: a 12-bit zero-extended immediate, a register value passed through a barrel shifter, an 8-bit immediate assembled from two nibbles of the instruction, or an unshifted register. The offset sign comes from the up/down control. A negative offset is turned into its two's complement, so a single adder handles both directions.

Three indexing modes are supported. In post-index mode the access uses the unmodified base and the base is always written back with base plus offset. In pre-index mode the access uses base plus offset, and writeback happens only when requested. The block also decodes the access width and whether loaded data must be sign-extended. It includes a combinational formatter that turns raw lane-0 load data into a 32-bit register value. Results are registered, so they appear one cycle after a valid request.

Top module: `ls_addr_gen`

## Requirements
- R1: With pre_idx=0 (post-index), eff_addr equals base_val and wb_en is 1 whatever wb_bit is, with wb_data = base_val + signed offset.
- R2: With pre_idx=1, eff_addr equals base_val + signed offset, and wb_en equals wb_bit. wb_data always holds the sum.
- R3: The outputs register the request sampled at the rising edge where in_valid=1, and out_valid is 1 for that following cycle only. When in_valid=0, out_valid and wb_en are 0 the next cycle. Reset (rst_n low) clears out_valid and wb_en.
- R4: add_up=1 adds the offset and add_up=0 subtracts it, both modulo 2^32.
- R5: With half_fam=0 and reg_off=0, the offset is inst_lo[11:0] zero-extended.
- R6: With half_fam=0 and reg_off=1, the offset is index_val shifted by inst_lo[11:7] using the kind in inst_lo[6:5]: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. An amount of 0 means no shift for kind 00, a result of 0 for kind 01, a copy of the sign bit for kind 10, and a one-bit rotate through carry_in for kind 11.
- R7: With half_fam=1, reg_off=0 selects the immediate {inst_lo[11:8], inst_lo[3:0]} zero-extended, and reg_off=1 selects index_val unshifted.
- R8: acc_size is encoded 00 byte, 01 halfword, 10 word. With half_fam=0, byte_sel=1 gives byte and byte_sel=0 gives word. With half_fam=1, hs_code 01 gives an unsigned halfword, 10 a signed byte and 11 a signed halfword, and byte_sel has no effect.
- R9: With half_fam=1, hs_code=00 or a signed hs_code with is_load=0 sets bad_form=1 and forces wb_en=0. eff_addr is still computed.
- R10: ld_data zero-extends ld_raw for unsigned byte and halfword accesses, sign-extends it for signed ones, and passes it through unchanged for words.
- R11: sext_en is 1 only for a legal signed load (half_fam=1, hs_code[1]=1, is_load=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid this cycle |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| inst_lo | input | 12 | Low instruction field: immediate, shift controls or split nibbles |
| half_fam | input | 1 | 1 selects the halfword/signed family |
| reg_off | input | 1 | 1 selects a register offset |
| pre_idx | input | 1 | 1 pre-index, 0 post-index |
| add_up | input | 1 | 1 add offset, 0 subtract |
| byte_sel | input | 1 | Byte access in the word family |
| wb_bit | input | 1 | Writeback request for pre-index |
| is_load | input | 1 | 1 load, 0 store |
| hs_code | input | 2 | Halfword family form: 01 uh, 10 sb, 11 sh |
| carry_in | input | 1 | Carry used by rotate-through-carry |
| ld_raw | input | 32 | Raw load data, lane 0 aligned |
| out_valid | output | 1 | Registered result valid |
| eff_addr | output | 32 | Access address |
| wb_data | output | 32 | Base plus signed offset |
| wb_en | output | 1 | Base writeback enable |
| acc_size | output | 2 | Access width code |
| sext_en | output | 1 | Load data sign-extension |
| bad_form | output | 1 | Illegal halfword-family combination |
| ld_data | output | 32 | Formatted load data |

## Verification
The bench targets the zero-amount shift encodings. A shifter that treated amount 0 literally would return the index unchanged for the right shifts and rotate, when the expected results are zero, a sign fill, or a carry-in rotate. It drives post-index requests with wb_bit low, where a design that gated writeback on wb_bit would drop the base update. Subtraction that wraps below zero and the 0xFFF immediate test the negation path. Signed stores and the 00 form must raise bad_form and suppress writeback. The bench also loads 0x80 and 0x8000 patterns, where a formatter that used the wrong extension rule would give 0x80 instead of 0xFFFFFF80.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    acc_size_e size;
    logic      sext;
    logic      ok;
  } form_s;
endpackage

// File: rtl/lsa_offset_sel.sv
module lsa_offset_sel #(
  parameter int DW = 32,
  parameter int IW = 12
) (
  input  logic [DW-1:0] index_val,
  input  logic [IW-1:0] inst_lo,
  input  logic          half_fam,
  input  logic          reg_off,
  input  logic          add_up,
  input  logic          carry_in,
  output logic [DW-1:0] off_mag,
  output logic [DW-1:0] off_adj
);
  import lsa_pkg::*;

  localparam int AMT_HI  = 11;
  localparam int AMT_LO  = 7;
  localparam int KIND_HI = 6;
  localparam int KIND_LO = 5;

  function automatic logic [DW-1:0] shift_val(
    input logic [DW-1:0] v,
    input logic [1:0]    kind,
    input logic [4:0]    amt,
    input logic          cin
  );
    logic [2*DW-1:0] wide;
    int n;
    n = (amt == 5'd0) ? DW : int'(amt);
    shift_val = v;
    case (shift_kind_e'(kind))
      SH_LSL: shift_val = v << amt;
      SH_LSR: shift_val = (amt == 5'd0) ? '0 : (v >> amt);
      SH_ASR: begin
        wide = {{DW{v[DW-1]}}, v};
        wide = wide >> n;
        shift_val = wide[DW-1:0];
      end
      SH_ROR: begin
        if (amt == 5'd0) shift_val = {cin, v[DW-1:1]};
        else begin
          wide = {v, v} >> n;
          shift_val = wide[DW-1:0];
        end
      end
      default: shift_val = v;
    endcase
  endfunction

  function automatic logic [DW-1:0] split_imm(input logic [IW-1:0] f);
    split_imm = DW'({f[11:8], f[3:0]});
  endfunction

  always_comb begin
    if (half_fam) off_mag = reg_off ? index_val : split_imm(inst_lo);
    else if (reg_off)
      off_mag = shift_val(index_val, inst_lo[KIND_HI:KIND_LO],
                          inst_lo[AMT_HI:AMT_LO], carry_in);
    else off_mag = DW'(inst_lo);
  end

  assign off_adj = add_up ? off_mag : (~off_mag + DW'(1));
endmodule

// File: rtl/lsa_form_dec.sv
module lsa_form_dec (
  input  logic          half_fam,
  input  logic          byte_sel,
  input  logic          is_load,
  input  logic [1:0]    hs_code,
  output lsa_pkg::form_s form
);
  import lsa_pkg::*;

  always_comb begin
    form.ok   = 1'b1;
    form.sext = 1'b0;
    form.size = SZ_WORD;
    if (!half_fam) begin
      form.size = byte_sel ? SZ_BYTE : SZ_WORD;
    end else begin
      case (hs_code)
        2'b01: form.size = SZ_HALF;
        2'b10: begin form.size = SZ_BYTE; form.sext = 1'b1; form.ok = is_load; end
        2'b11: begin form.size = SZ_HALF; form.sext = 1'b1; form.ok = is_load; end
        default: begin form.size = SZ_HALF; form.ok = 1'b0; end
      endcase
    end
    form.sext = form.sext & form.ok;
  end
endmodule

// File: rtl/lsa_index_ctl.sv
module lsa_index_ctl #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] off_adj,
  input  logic          pre_idx,
  input  logic          wb_bit,
  input  logic          form_ok,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wb_val,
  output logic          wb_req
);
  logic [DW-1:0] sum;
  assign sum    = base_val + off_adj;
  assign addr   = pre_idx ? sum : base_val;
  assign wb_val = sum;
  assign wb_req = form_ok & (~pre_idx | wb_bit);
endmodule

// File: rtl/lsa_load_fmt.sv
module lsa_load_fmt #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] raw,
  input  logic [1:0]    size,
  input  logic          sext,
  output logic [DW-1:0] data
);
  import lsa_pkg::*;

  function automatic logic [DW-1:0] extend(input logic [DW-1:0] v, input int bits, input logic s);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (i < bits) ? v[i] : (s & v[bits-1]);
    return r;
  endfunction

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: data = extend(raw, 8, sext);
      SZ_HALF: data = extend(raw, 16, sext);
      default: data = raw;
    endcase
  end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int DW = 32,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] index_val,
  input  logic [IW-1:0] inst_lo,
  input  logic          half_fam,
  input  logic          reg_off,
  input  logic          pre_idx,
  input  logic          add_up,
  input  logic          byte_sel,
  input  logic          wb_bit,
  input  logic          is_load,
  input  logic [1:0]    hs_code,
  input  logic          carry_in,
  input  logic [DW-1:0] ld_raw,
  output logic          out_valid,
  output logic [DW-1:0] eff_addr,
  output logic [DW-1:0] wb_data,
  output logic          wb_en,
  output logic [1:0]    acc_size,
  output logic          sext_en,
  output logic          bad_form,
  output logic [DW-1:0] ld_data
);
  import lsa_pkg::*;

  logic [DW-1:0] off_mag_w, off_adj_w, addr_w, wb_val_w;
  logic          wb_req_w, form_ok_w;
  form_s         form_w;

  lsa_offset_sel #(.DW(DW), .IW(IW)) u_off (
    .index_val(index_val), .inst_lo(inst_lo), .half_fam(half_fam),
    .reg_off(reg_off), .add_up(add_up), .carry_in(carry_in),
    .off_mag(off_mag_w), .off_adj(off_adj_w)
  );

  lsa_form_dec u_form (
    .half_fam(half_fam), .byte_sel(byte_sel), .is_load(is_load),
    .hs_code(hs_code), .form(form_w)
  );

  assign form_ok_w = form_w.ok;

  lsa_index_ctl #(.DW(DW)) u_idx (
    .base_val(base_val), .off_adj(off_adj_w), .pre_idx(pre_idx),
    .wb_bit(wb_bit), .form_ok(form_ok_w), .addr(addr_w),
    .wb_val(wb_val_w), .wb_req(wb_req_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      eff_addr  <= '0;
      wb_data   <= '0;
      acc_size  <= SZ_WORD;
      sext_en   <= 1'b0;
      bad_form  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & wb_req_w;
      if (in_valid) begin
        eff_addr <= addr_w;
        wb_data  <= wb_val_w;
        acc_size <= form_w.size;
        sext_en  <= form_w.sext;
        bad_form <= ~form_w.ok;
      end
    end
  end

  lsa_load_fmt #(.DW(DW)) u_fmt (
    .raw(ld_raw), .size(acc_size), .sext(sext_en), .data(ld_data)
  );
endmodule

// File: rtl/lsa_chk.sv
module lsa_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          pre_idx,
  input logic [DW-1:0] base_val,
  input logic          form_ok_w,
  input logic          out_valid,
  input logic [DW-1:0] eff_addr,
  input logic [DW-1:0] wb_data,
  input logic          wb_en,
  input logic [1:0]    acc_size,
  input logic          sext_en,
  input logic          bad_form
);
  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wb_en));
  // R1
  post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pre_idx && form_ok_w) |=> (wb_en && eff_addr == $past(base_val)));
  // R2
  pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pre_idx) |=> (eff_addr == wb_data));
  // R9
  bad_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> !wb_en);
  // R11
  sext_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sext_en |-> (acc_size != 2'b10 && !bad_form));
endmodule

bind ls_addr_gen lsa_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pre_idx(pre_idx),
  .base_val(base_val), .form_ok_w(form_ok_w), .out_valid(out_valid),
  .eff_addr(eff_addr), .wb_data(wb_data), .wb_en(wb_en),
  .acc_size(acc_size), .sext_en(sext_en), .bad_form(bad_form)
);

// File: tb/ls_addr_gen_tb.sv
module ls_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] base_val = '0, index_val = '0, ld_raw = '0;
  logic [11:0] inst_lo = '0;
  logic        half_fam = 0, reg_off = 0, pre_idx = 0, add_up = 1;
  logic        byte_sel = 0, wb_bit = 0, is_load = 1, carry_in = 0;
  logic [1:0]  hs_code = 2'b01;
  logic        out_valid, wb_en, sext_en, bad_form;
  logic [31:0] eff_addr, wb_data, ld_data;
  logic [1:0]  acc_size;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ls_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .index_val(index_val), .inst_lo(inst_lo), .half_fam(half_fam),
    .reg_off(reg_off), .pre_idx(pre_idx), .add_up(add_up),
    .byte_sel(byte_sel), .wb_bit(wb_bit), .is_load(is_load),
    .hs_code(hs_code), .carry_in(carry_in), .ld_raw(ld_raw),
    .out_valid(out_valid), .eff_addr(eff_addr), .wb_data(wb_data),
    .wb_en(wb_en), .acc_size(acc_size), .sext_en(sext_en),
    .bad_form(bad_form), .ld_data(ld_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_offset();
    logic [63:0] w;
    int a;
    a = int'(inst_lo[11:7]);
    if (half_fam) return reg_off ? index_val : {24'd0, inst_lo[11:8], inst_lo[3:0]};
    if (!reg_off) return {20'd0, inst_lo};
    case (inst_lo[6:5])
      2'b00: begin w = {32'd0, index_val} * (64'd1 << a); return w[31:0]; end
      2'b01: return (a == 0) ? 32'd0 : index_val >> a;
      2'b10: return (a == 0) ? {32{index_val[31]}} : 32'($signed(index_val) >>> a);
      default: begin
        if (a == 0) return {carry_in, index_val[31:1]};
        w = {index_val, index_val} >> a;
        return w[31:0];
      end
    endcase
  endfunction

  function automatic bit m_ok();
    if (!half_fam) return 1;
    if (hs_code == 2'b00) return 0;
    return !(hs_code[1] && !is_load);
  endfunction

  function automatic logic [1:0] m_size();
    if (!half_fam) return byte_sel ? 2'b00 : 2'b10;
    return (hs_code == 2'b10) ? 2'b00 : 2'b01;
  endfunction

  function automatic logic [31:0] m_load(input logic [1:0] sz, input bit s);
    if (sz == 2'b00) return s ? {{24{ld_raw[7]}}, ld_raw[7:0]} : {24'd0, ld_raw[7:0]};
    if (sz == 2'b01) return s ? {{16{ld_raw[15]}}, ld_raw[15:0]} : {16'd0, ld_raw[15:0]};
    return ld_raw;
  endfunction

  task automatic fire(input logic [31:0] raw);
    logic [31:0] off, sum;
    bit ok, s;
    logic [1:0] sz;
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ld_raw = raw;
    #1;
    off = m_offset();
    sum = add_up ? base_val + off : base_val - off;
    ok = m_ok();
    sz = m_size();
    s = ok && half_fam && hs_code[1];
    chk("R3 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R4/R5/R6/R7 wb_data", wb_data, sum);
    chk("R1/R2 eff_addr", eff_addr, pre_idx ? sum : base_val);
    chk("R1/R2/R9 wb_en", {31'd0, wb_en}, {31'd0, ok && (!pre_idx || wb_bit)});
    chk("R9 bad_form", {31'd0, bad_form}, {31'd0, !ok});
    if (ok) begin
      chk("R8 acc_size", {30'd0, acc_size}, {30'd0, sz});
      chk("R11 sext_en", {31'd0, sext_en}, {31'd0, s});
      chk("R10 ld_data", ld_data, m_load(sz, s));
    end
  endtask

  task automatic set_fields(input bit hf, input bit ro, input bit p, input bit u,
                            input bit bs, input bit w, input bit l, input logic [1:0] hs);
    half_fam = hf; reg_off = ro; pre_idx = p; add_up = u;
    byte_sel = bs; wb_bit = w; is_load = l; hs_code = hs;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R3 reset wb_en", {31'd0, wb_en}, 32'd0);
    rst_n = 1'b1;

    // R1: post-index, wb_bit low still writes back
    base_val = 32'h1000; inst_lo = 12'h010;
    set_fields(0, 0, 0, 1, 0, 0, 1, 2'b01);
    fire(32'h0);
    // R2: pre-index without writeback
    set_fields(0, 0, 1, 1, 0, 0, 1, 2'b01);
    fire(32'h0);
    // R2: pre-index with writeback
    set_fields(0, 0, 1, 1, 0, 1, 0, 2'b01);
    fire(32'h0);
    // R4: subtract that wraps; R5 max immediate
    base_val = 32'h4; inst_lo = 12'hFFF;
    set_fields(0, 0, 1, 0, 1, 0, 1, 2'b01);
    fire(32'h80);
    // R6: each shift kind with amount 0 and nonzero
    index_val = 32'h8000_0003; base_val = 32'h100;
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 2; c++) begin
        carry_in = c[0];
        inst_lo = {5'd0, k[1:0], 5'd0};
        set_fields(0, 1, 1, 1, 0, 0, 1, 2'b01);
        fire(32'h0);
        inst_lo = {5'd3, k[1:0], 5'd0};
        fire(32'h0);
      end
    end
    // R7: split immediate 0xAB, R10 signed byte 0x80
    base_val = 32'h2000; inst_lo = 12'hA5B;
    set_fields(1, 0, 1, 1, 1, 0, 1, 2'b10);
    fire(32'h0000_0080);
    // R8: byte_sel ignored in half family, signed half 0x8000
    set_fields(1, 1, 0, 1, 1, 1, 1, 2'b11);
    index_val = 32'h20;
    fire(32'h1234_8000);
    // R9: signed store and code 00
    set_fields(1, 0, 0, 1, 0, 1, 0, 2'b11);
    fire(32'h0);
    set_fields(1, 0, 1, 1, 0, 1, 1, 2'b00);
    fire(32'h0);
    // R3: idle cycle drops out_valid
    @(negedge clk);
    chk("R3 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R3 idle wb_en", {31'd0, wb_en}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      base_val = $urandom; index_val = $urandom; inst_lo = 12'($urandom);
      carry_in = 1'($urandom);
      set_fields(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
      fire($urandom);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule